// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Aligner with Automatic Interworking

This block runs beside an E1 receive framer and starts once basic frame alignment is held. For every received frame it takes bit 1 of timeslot 0, along with a flag that says whether that frame carries the non-frame-alignment word (NFAS, the odd frames). In the NFAS frames it looks for the six-bit CRC-4 multiframe alignment word. One match fixes a candidate phase. A second match, exactly one multiframe (16 frames) later, declares CRC-4 multiframe sync. From then on the block supplies the position of each frame within the 16-frame multiframe.

If basic alignment holds for a whole timeout window and CRC-4 sync still has not been reached, the block classes the far end as an interface without CRC-4 processing. It then raises a status flag, tells the receive side to suspend CRC-4 checking, and tells the transmit side to keep sending CRC-4 with the E-bits held at zero. This fallback can be switched off. Losing basic alignment drops everything back to the start. The block does not compute any CRC.

Top module: `crc4_mf_aligner`

## Requirements
- R1: After reset, `crc_sync`, `far_noncrc`, `rx_crc_hold` and `tx_ebit_zero` are 0 and `fidx` is 0.
- R2: The search only advances on a cycle with `frm_vld` high while `bsync` is high. It only reads `ts0_b1` on frames with `frm_nfas`=1. Frames received while `bsync` is low, and the bit-1 values of FAS frames (`frm_nfas`=0), have no effect.
- R3: The alignment word is 001011, read oldest bit first, from the NFAS frames at multiframe positions 1, 3, 5, 7, 9 and 11. A word that completes in one NFAS frame makes that frame position 11 of a candidate. `crc_sync` rises at the clock edge that samples the frame completing a second word exactly 16 frames later.
- R4: If the frame 16 frames after a candidate does not complete the word, the candidate is dropped and the search restarts. A later pair of consecutive words still gives sync.
- R5: On the edge where `crc_sync` rises, `fidx` is 11. While synced, `fidx` steps by one, modulo 16, on every frame strobe.
- R6: Frame strobes with `bsync` high are counted from the time `bsync` rises. If sync has not been reached by frame number TMO_FRAMES, `far_noncrc` rises on the edge that samples that frame. If a second word completes on that same frame, sync is declared and `far_noncrc` stays 0.
- R7: `rx_crc_hold` and `tx_ebit_zero` are high exactly when `far_noncrc` is high.
- R8: With `iw_off`=1, `far_noncrc` never rises. The search continues without a time limit.
- R9: `bsync` low clears `crc_sync`, `far_noncrc` and `fidx` on the next clock edge and restarts the timeout count.
- R10: Once `far_noncrc` is set, the search stops. `crc_sync` stays 0 until `bsync` is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | One-cycle strobe per received frame |
| frm_nfas | input | 1 | 1 when the strobed frame is an NFAS frame |
| ts0_b1 | input | 1 | Bit 1 of timeslot 0 of the strobed frame |
| bsync | input | 1 | Basic frame alignment held |
| iw_off | input | 1 | 1 disables the automatic interworking timeout |
| crc_sync | output | 1 | CRC-4 multiframe sync |
| fidx | output | 4 | Position of the last frame within the multiframe (0 to 15) |
| far_noncrc | output | 1 | Far end classed as non-CRC-4 |
| rx_crc_hold | output | 1 | Suspend receive CRC-4 checking |
| tx_ebit_zero | output | 1 | Transmit E-bits forced to zero |

## Verification
Every result is registered once. It is due on the same rising edge that samples the frame strobe that causes it: the sync decision, the index step and the timeout. The exception is loss of `bsync`, which clears the outputs on the first edge after it falls, with or without a strobe.

The bench drives each strobe on a falling edge and holds it for one cycle. It samples the outputs at the next falling edge, so the capturing edge lies between the drive and the sample. Each table vector and directed case checks its outputs only after its last strobe has been captured. Vectors are placed one frame before and exactly on the sync frame and the timeout frame, so a result that is one frame late or early shows up.

// File: rtl/crc4_mf_aligner.sv
module crc4_mf_aligner #(
  parameter int TMO_FRAMES = 3200,
  parameter logic [5:0] MFA_WORD = 6'b001011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_vld,
  input  logic       frm_nfas,
  input  logic       ts0_b1,
  input  logic       bsync,
  input  logic       iw_off,
  output logic       crc_sync,
  output logic [3:0] fidx,
  output logic       far_noncrc,
  output logic       rx_crc_hold,
  output logic       tx_ebit_zero
);
  localparam int TW = $clog2(TMO_FRAMES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TMO_FRAMES - 1);

  typedef enum logic [1:0] {S_HUNT, S_CAND, S_LOCK, S_NOCRC} st_t;

  st_t           st;
  logic [5:0]    win;
  logic [3:0]    idx;
  logic [TW-1:0] tmr;

  wire [5:0] win_nx  = {win[4:0], ts0_b1};
  wire       nfas_ev = frm_vld & frm_nfas;
  wire       hit     = nfas_ev & (win_nx == MFA_WORD);
  wire       tmo     = frm_vld & (tmr == TLAST) & ~iw_off;
  wire       hunting = (st == S_HUNT) | (st == S_CAND);

  always_ff @(posedge clk) begin
    if (!rst_n || !bsync) begin
      st  <= S_HUNT;
      win <= '1;
      idx <= '0;
      tmr <= '0;
    end else begin
      if (nfas_ev) win <= win_nx;
      if (frm_vld && hunting && tmr != TLAST) tmr <= tmr + 1'b1;
      if (frm_vld) begin
        case (st)
          S_HUNT: begin
            if (tmo) st <= S_NOCRC;
            else if (hit) begin
              st  <= S_CAND;
              idx <= 4'd11;
            end
          end
          S_CAND: begin
            if (idx == 4'd10) begin
              if (hit) begin
                st  <= S_LOCK;
                idx <= 4'd11;
              end else begin
                st  <= tmo ? S_NOCRC : S_HUNT;
                idx <= '0;
              end
            end else if (tmo) begin
              st  <= S_NOCRC;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          S_LOCK:  idx <= idx + 1'b1;
          default: idx <= '0;
        endcase
      end
    end
  end

  assign crc_sync     = (st == S_LOCK);
  assign far_noncrc   = (st == S_NOCRC);
  assign rx_crc_hold  = far_noncrc;
  assign tx_ebit_zero = far_noncrc;
  assign fidx         = idx;
endmodule

module crc4_mf_aligner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_vld,
  input logic       bsync,
  input logic       iw_off,
  input logic       crc_sync,
  input logic [3:0] fidx,
  input logic       far_noncrc
);
  // R3
  sync_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_sync) |-> $past(frm_vld && bsync));

  // R5
  sync_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_sync) |-> fidx == 4'd11);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_sync && frm_vld && bsync) |=> fidx == $past(fidx) + 4'd1);

  // R9
  bsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bsync |=> (!crc_sync && !far_noncrc && fidx == 4'd0));

  // R8
  iw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(far_noncrc) |-> $past(frm_vld && !iw_off));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsync && !frm_vld) |=> ($stable(crc_sync) && $stable(far_noncrc) && $stable(fidx)));
endmodule

bind crc4_mf_aligner crc4_mf_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .bsync(bsync), .iw_off(iw_off),
  .crc_sync(crc_sync), .fidx(fidx), .far_noncrc(far_noncrc)
);

// File: tb/crc4_mf_aligner_tb.sv
module crc4_mf_aligner_tb;
  localparam int TMO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_vld = 1'b0, frm_nfas = 1'b0, ts0_b1 = 1'b1, bsync = 1'b0, iw_off = 1'b0;
  logic crc_sync, far_noncrc, rx_crc_hold, tx_ebit_zero;
  logic [3:0] fidx;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  crc4_mf_aligner #(.TMO_FRAMES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_nfas(frm_nfas), .ts0_b1(ts0_b1),
    .bsync(bsync), .iw_off(iw_off), .crc_sync(crc_sync), .fidx(fidx),
    .far_noncrc(far_noncrc), .rx_crc_hold(rx_crc_hold), .tx_ebit_zero(tx_ebit_zero));

  // {start pos[4], frames[8], iw_off, corrupt[2], exp sync, exp noncrc, exp idx[4]}
  // corrupt: 0 clean, 1 every word broken, 2 second word broken
  localparam logic [20:0] VEC [12] = '{
    {4'd0,  8'd40, 1'b0, 2'd0, 1'b1, 1'b0, 4'd7},
    {4'd2,  8'd41, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0},
    {4'd2,  8'd42, 1'b0, 2'd0, 1'b1, 1'b0, 4'd11},
    {4'd12, 8'd50, 1'b0, 2'd0, 1'b1, 1'b0, 4'd13},
    {4'd0,  8'd70, 1'b0, 2'd1, 1'b0, 1'b1, 4'd0},
    {4'd0,  8'd70, 1'b1, 2'd1, 1'b0, 1'b0, 4'd0},
    {4'd0,  8'd60, 1'b0, 2'd2, 1'b1, 1'b0, 4'd11},
    {4'd2,  8'd70, 1'b0, 2'd2, 1'b0, 1'b1, 4'd0},
    {4'd5,  8'd64, 1'b0, 2'd0, 1'b1, 1'b0, 4'd4},
    {4'd7,  8'd63, 1'b0, 2'd1, 1'b0, 1'b0, 4'd0},
    {4'd7,  8'd64, 1'b0, 2'd1, 1'b0, 1'b1, 4'd0},
    {4'd12, 8'd64, 1'b0, 2'd2, 1'b1, 1'b0, 4'd11}
  };

  task automatic chk(input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic send_frame(input bit nfas, input bit b1);
    @(negedge clk);
    frm_nfas = nfas;
    ts0_b1   = b1;
    frm_vld  = 1'b1;
    @(negedge clk);
    frm_vld  = 1'b0;
  endtask

  function automatic bit mf_bit(input int pos, input bit fas_b);
    if (pos % 2 == 0) return fas_b;
    case (pos)
      1, 3, 7: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_stream(input int s, input int n, input int cor, input bit fasb);
    int fc;
    fc = 10 + (((1 - s) % 16) + 16) % 16;
    for (int f = 0; f < n; f++) begin
      int pos;
      bit b;
      pos = (s + f) % 16;
      b = mf_bit(pos, fasb);
      if (pos == 5 && (cor == 1 || (cor == 2 && f >= fc + 6 && f <= fc + 16))) b = ~b;
      send_frame(pos % 2 == 1, b);
    end
  endtask

  task automatic restart(input bit iw);
    @(negedge clk);
    bsync  = 1'b0;
    iw_off = iw;
    @(negedge clk);
    bsync  = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset crc_sync", crc_sync, 0);
    chk("R1 reset far_noncrc", far_noncrc, 0);
    chk("R1 reset fidx", fidx, 0);
    chk("R1 reset rx_crc_hold", rx_crc_hold, 0);
    chk("R1 reset tx_ebit_zero", tx_ebit_zero, 0);

    for (int i = 0; i < 12; i++) begin
      logic [20:0] v;
      v = VEC[i];
      restart(v[8]);
      run_stream(int'(v[20:17]), int'(v[16:9]), int'(v[7:6]), 1'b1);
      chk($sformatf("R3/R4 vec%0d crc_sync", i), crc_sync, v[5]);
      chk($sformatf("R6/R8 vec%0d far_noncrc", i), far_noncrc, v[4]);
      chk($sformatf("R7 vec%0d rx_crc_hold", i), rx_crc_hold, v[4]);
      chk($sformatf("R7 vec%0d tx_ebit_zero", i), tx_ebit_zero, v[4]);
      if (v[5]) chk($sformatf("R5 vec%0d fidx", i), fidx, int'(v[3:0]));
    end

    // R9: loss of basic alignment clears sync without any frame strobe
    restart(1'b0);
    run_stream(0, 40, 0, 1'b1);
    chk("R9 sync before loss", crc_sync, 1);
    @(negedge clk); bsync = 1'b0;
    @(negedge clk);
    chk("R9 sync cleared", crc_sync, 0);
    chk("R9 fidx cleared", fidx, 0);

    // R10: after the timeout, a clean stream does not sync
    restart(1'b0);
    run_stream(0, 64, 1, 1'b1);
    chk("R6 timeout reached", far_noncrc, 1);
    run_stream(0, 40, 0, 1'b1);
    chk("R10 no sync after noncrc", crc_sync, 0);
    chk("R10 noncrc held", far_noncrc, 1);
    @(negedge clk); bsync = 1'b0;
    @(negedge clk);
    chk("R9 noncrc cleared", far_noncrc, 0);
    chk("R9 rx_crc_hold cleared", rx_crc_hold, 0);
    bsync = 1'b1;
    run_stream(0, 63, 1, 1'b1);
    chk("R9 timer restarted 63 frames", far_noncrc, 0);
    send_frame(1'b1, 1'b1);
    chk("R9 timer restarted 64th frame", far_noncrc, 1);

    // R2: frames without basic sync are ignored; FAS bit-1 values ignored
    @(negedge clk); bsync = 1'b0;
    run_stream(0, 40, 0, 1'b0);
    chk("R2 no sync while bsync low", crc_sync, 0);
    bsync = 1'b1;
    run_stream(8, 20, 0, 1'b0);
    chk("R2 only candidate after 20 frames", crc_sync, 0);
    run_stream(12, 16, 0, 1'b0);
    chk("R2 sync with FAS bits zero", crc_sync, 1);
    chk("R5 fidx at sync", fidx, 11);
    send_frame(1'b0, 1'b0);
    chk("R5 fidx steps", fidx, 12);
    repeat (3) @(negedge clk);
    chk("R2 fidx holds without strobe", fidx, 12);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule